// File: doc/BRIEF.md
# Multiplexed-Bus Register File with Gated Wipe

This block is a slave memory and register space reached over an 8-bit bus that carries the address and the data on the same lines at different times. An address strobe marks the address phase. The block latches the address when that strobe falls. A write strobe (active low) commits the bus byte when it rises. A read strobe (active low) makes the block drive the addressed byte for as long as it is held low. The block uses a separate input and output byte plus an output enable, so a pad ring can join them into one tri-state bus.

Behind the bus sit 114 bytes of user RAM, a small set of fixed-value registers, one bank-control register and a bank-1 extended space. The extended space holds a wipe-enable bit, an auxiliary-supply enable and a crystal-load select. When software has set the wipe-enable bit, a falling edge on the active-low wipe input erases the user RAM one byte per clock. Bus writes to the RAM are dropped until the erase is done.

The strobes are plain level pins. They have no back-pressure and no handshake, because each access takes a fixed number of clocks. All strobes are sampled on `clk`.

Top module: `mxrf_regfile`

## Requirements
- R1: The address is taken from `bus_in` at the first clock edge that sees `addr_strobe` low after it was high. Later changes on `bus_in` do not move the latched address until the next such fall.
- R2: A write commits `bus_in` to the latched address at the first clock edge that sees `wr_strobe_n` high after it was low. The byte present at that edge is the one stored.
- R3: `bus_oe` is high only while `rd_strobe_n` is low and `addr_strobe` is low. It drops in the same cycle that `rd_strobe_n` rises. While `bus_oe` is high, `bus_out` carries the addressed byte.
- R4: Addresses 0x0E to 0x3F always map to user RAM. Addresses 0x40 to 0x7F also map to user RAM while bank 0 is selected. Together these are 114 read/write bytes.
- R5: Addresses 0x00 to 0x09 and 0x0B to 0x0D read as 0xC0 OR address. Writes to them are ignored.
- R6: Address 0x0A is an 8-bit read/write register, reset to 0x00. Its bit 4 selects bank 1 when set.
- R7: With bank 1 selected, 0x4A bit 0 is the wipe enable and its other bits read 0. 0x4B bit 0 drives `aux_supply_en` and bit 1 drives `xtal_load_sel`; its other bits read 0. All other addresses from 0x40 to 0x7F read 0x00, ignore writes and leave the bank-0 RAM untouched.
- R8: Addresses 0x80 to 0xFF read 0x00 and ignore writes.
- R9: A falling edge on `wipe_n` while the wipe enable is 1 zeroes all 114 RAM bytes, one per clock, within 116 clocks. A falling edge while the enable is 0 changes nothing.
- R10: While a wipe runs, bus writes to user RAM are ignored. Writes to registers still take effect.
- R11: After reset, the bank select, wipe enable, `aux_supply_en`, `xtal_load_sel` and `bus_oe` are all 0, and register 0x0A reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_strobe | input | 1 | Address phase strobe; address latched on its fall |
| rd_strobe_n | input | 1 | Active-low read strobe |
| wr_strobe_n | input | 1 | Active-low write strobe; data committed on its rise |
| bus_in | input | 8 | Bus byte as seen by the block |
| bus_out | output | 8 | Read data (0 when not driving) |
| bus_oe | output | 1 | Output enable for the bus drivers |
| wipe_n | input | 1 | Active-low RAM wipe request |
| aux_supply_en | output | 1 | Auxiliary supply enable bit |
| xtal_load_sel | output | 1 | Crystal load select bit |

## Verification
The latched address and a committed write both take effect at the first rising clock edge that sees the strobe's new level. The bench changes the strobes at falling edges and holds the bus byte for one more half cycle, so each access is complete before the next step begins. Read data and `bus_oe` follow the strobes without a register stage. The bench therefore samples them 2 ns after lowering the read strobe and 1 ns after raising it. The wipe starts one edge after the fall is seen and runs for 114 edges. The bench waits 130 cycles before reading the RAM back, and it places writes it expects to be dropped well inside that window.

// File: rtl/mxrf_pkg.sv
package mxrf_pkg;
  localparam int DW = 8;

  typedef enum logic [2:0] {
    RGN_FIXED,
    RGN_BANKSEL,
    RGN_RAM,
    RGN_WIPECFG,
    RGN_XCTL,
    RGN_NONE
  } region_e;
endpackage

// File: rtl/mxrf_bus_sync.sv
module mxrf_bus_sync #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_strobe,
  input  logic          rd_strobe_n,
  input  logic          wr_strobe_n,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] addr_q,
  output logic          wr_pulse,
  output logic          bus_oe
);
  logic as_q;
  logic wr_q;
  logic as_fall;

  assign as_fall  = as_q && !addr_strobe;
  assign wr_pulse = !wr_q && wr_strobe_n;
  assign bus_oe   = !rd_strobe_n && !addr_strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      as_q   <= 1'b0;
      wr_q   <= 1'b1;
      addr_q <= '0;
    end else begin
      as_q <= addr_strobe;
      wr_q <= wr_strobe_n;
      if (as_fall) addr_q <= bus_in;
    end
  end

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(as_q && !addr_strobe) |=> $stable(addr_q)); // R1
endmodule

// File: rtl/mxrf_decode.sv
module mxrf_decode
  import mxrf_pkg::*;
#(
  parameter int DW           = 8,
  parameter int RAM_BASE     = 14,
  parameter int RAM_BYTES    = 114,
  parameter int BANK_LO      = 64,
  parameter int BANKSEL_ADDR = 10,
  parameter int WIPECFG_ADDR = 74,
  parameter int XCTL_ADDR    = 75,
  parameter int IW           = 7
) (
  input  logic [DW-1:0] addr,
  input  logic          bank,
  output region_e       region,
  output logic [IW-1:0] ram_idx
);
  localparam int RAM_END = RAM_BASE + RAM_BYTES;

  logic [DW:0]   ax;
  logic [DW-1:0] off;

  assign ax  = {1'b0, addr};
  assign off = addr - DW'(RAM_BASE);

  always_comb begin
    ram_idx = off[IW-1:0];
    if (ax < (DW+1)'(RAM_BASE)) begin
      region = (ax == (DW+1)'(BANKSEL_ADDR)) ? RGN_BANKSEL : RGN_FIXED;
    end else if (ax >= (DW+1)'(RAM_END)) begin
      region = RGN_NONE;
    end else if (bank && ax >= (DW+1)'(BANK_LO)) begin
      if (ax == (DW+1)'(WIPECFG_ADDR))   region = RGN_WIPECFG;
      else if (ax == (DW+1)'(XCTL_ADDR)) region = RGN_XCTL;
      else                               region = RGN_NONE;
    end else begin
      region = RGN_RAM;
    end
  end
endmodule

// File: rtl/mxrf_ctrl_regs.sv
module mxrf_ctrl_regs
  import mxrf_pkg::*;
#(
  parameter int DW       = 8,
  parameter int BANK_BIT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  region_e       region,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctl_byte,
  output logic          bank,
  output logic          wipe_en,
  output logic          aux_en,
  output logic          xtal_sel
);
  assign bank = ctl_byte[BANK_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_byte <= '0;
      wipe_en  <= 1'b0;
      aux_en   <= 1'b0;
      xtal_sel <= 1'b0;
    end else if (we) begin
      unique case (region)
        RGN_BANKSEL: ctl_byte <= wdata;
        RGN_WIPECFG: wipe_en  <= wdata[0];
        RGN_XCTL: begin
          aux_en   <= wdata[0];
          xtal_sel <= wdata[1];
        end
        default: ;
      endcase
    end
  end

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && region == RGN_BANKSEL) |=> $stable(ctl_byte)); // R6
  AST_EXT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && region == RGN_XCTL) |=> ($stable(aux_en) && $stable(xtal_sel))); // R7
endmodule

// File: rtl/mxrf_user_ram.sv
module mxrf_user_ram #(
  parameter int DW        = 8,
  parameter int RAM_BYTES = 114,
  parameter int IW        = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  input  logic          wipe_n,
  input  logic          wipe_en,
  output logic [DW-1:0] rdata
);
  localparam logic [IW-1:0] LAST = IW'(RAM_BYTES - 1);

  logic [DW-1:0] mem [RAM_BYTES];
  logic          wipe_q;
  logic          busy;
  logic [IW-1:0] widx;
  logic          start;

  assign start = !busy && wipe_q && !wipe_n && wipe_en;
  assign rdata = (idx <= LAST) ? mem[idx] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wipe_q <= 1'b1;
      busy   <= 1'b0;
      widx   <= '0;
    end else begin
      wipe_q <= wipe_n;
      if (start) begin
        busy <= 1'b1;
        widx <= '0;
      end else if (busy) begin
        if (widx == LAST) busy <= 1'b0;
        widx <= widx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (busy)                   mem[widx] <= '0;
    else if (we && idx <= LAST) mem[idx]  <= wdata;
  end

  AST_WIPE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> mem[$past(widx)] == '0); // R9
  AST_WIPE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wipe_en)); // R9
endmodule

// File: rtl/mxrf_regfile.sv
module mxrf_regfile
  import mxrf_pkg::*;
#(
  parameter int RAM_BASE     = 14,
  parameter int RAM_BYTES    = 114,
  parameter int BANK_LO      = 64,
  parameter int BANKSEL_ADDR = 10,
  parameter int WIPECFG_ADDR = 74,
  parameter int XCTL_ADDR    = 75,
  parameter int BANK_BIT     = 4,
  parameter logic [7:0] FIXED_TAG = 8'hC0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr_strobe,
  input  logic       rd_strobe_n,
  input  logic       wr_strobe_n,
  input  logic [7:0] bus_in,
  output logic [7:0] bus_out,
  output logic       bus_oe,
  input  logic       wipe_n,
  output logic       aux_supply_en,
  output logic       xtal_load_sel
);
  localparam int IW = $clog2(RAM_BYTES);

  logic [DW-1:0] addr_q;
  logic          wr_pulse;
  logic          bank;
  logic          wipe_en;
  logic [DW-1:0] ctl_byte;
  logic [DW-1:0] ram_rdata;
  logic [IW-1:0] ram_idx;
  logic [DW-1:0] rd_data;
  region_e       region;

  mxrf_bus_sync #(.DW(DW)) u_sync (
    .clk(clk), .rst_n(rst_n), .addr_strobe(addr_strobe),
    .rd_strobe_n(rd_strobe_n), .wr_strobe_n(wr_strobe_n), .bus_in(bus_in),
    .addr_q(addr_q), .wr_pulse(wr_pulse), .bus_oe(bus_oe)
  );

  mxrf_decode #(
    .DW(DW), .RAM_BASE(RAM_BASE), .RAM_BYTES(RAM_BYTES), .BANK_LO(BANK_LO),
    .BANKSEL_ADDR(BANKSEL_ADDR), .WIPECFG_ADDR(WIPECFG_ADDR),
    .XCTL_ADDR(XCTL_ADDR), .IW(IW)
  ) u_dec (
    .addr(addr_q), .bank(bank), .region(region), .ram_idx(ram_idx)
  );

  mxrf_ctrl_regs #(.DW(DW), .BANK_BIT(BANK_BIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(wr_pulse), .region(region), .wdata(bus_in),
    .ctl_byte(ctl_byte), .bank(bank), .wipe_en(wipe_en),
    .aux_en(aux_supply_en), .xtal_sel(xtal_load_sel)
  );

  mxrf_user_ram #(.DW(DW), .RAM_BYTES(RAM_BYTES), .IW(IW)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(wr_pulse && region == RGN_RAM),
    .idx(ram_idx), .wdata(bus_in), .wipe_n(wipe_n), .wipe_en(wipe_en),
    .rdata(ram_rdata)
  );

  always_comb begin
    unique case (region)
      RGN_FIXED:   rd_data = FIXED_TAG | addr_q;
      RGN_BANKSEL: rd_data = ctl_byte;
      RGN_RAM:     rd_data = ram_rdata;
      RGN_WIPECFG: rd_data = {7'b0, wipe_en};
      RGN_XCTL:    rd_data = {6'b0, xtal_load_sel, aux_supply_en};
      default:     rd_data = '0;
    endcase
  end

  assign bus_out = bus_oe ? rd_data : '0;

  AST_OE_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (!addr_strobe && !rd_strobe_n)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> bus_out == '0); // R3
endmodule

// File: tb/tb_mxrf_regfile.sv
module tb_mxrf_regfile;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       addr_strobe, rd_strobe_n, wr_strobe_n, wipe_n;
  logic [7:0] bus_in, bus_out;
  logic       bus_oe, aux_supply_en, xtal_load_sel;

  int n_run  = 0;
  int n_fail = 0;
  logic [7:0] rd_v;
  logic       oe_v;

  always #(CLK_PERIOD/2) clk = ~clk;

  mxrf_regfile dut (
    .clk(clk), .rst_n(rst_n), .addr_strobe(addr_strobe),
    .rd_strobe_n(rd_strobe_n), .wr_strobe_n(wr_strobe_n), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .wipe_n(wipe_n),
    .aux_supply_en(aux_supply_en), .xtal_load_sel(xtal_load_sel)
  );

  function automatic logic [7:0] pat(input int a, input int s);
    return 8'((a * 7 + s) & 255);
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic addr_cycle(input logic [7:0] a);
    @(negedge clk); addr_strobe = 1'b1; bus_in = a;
    @(negedge clk); addr_strobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr_cycle(a);
    bus_in = d; wr_strobe_n = 1'b0;
    @(negedge clk); wr_strobe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd_cur();
    rd_strobe_n = 1'b0;
    #2; rd_v = bus_out; oe_v = bus_oe;
    @(negedge clk); rd_strobe_n = 1'b1;
  endtask

  task automatic rd(input logic [7:0] a);
    addr_cycle(a);
    rd_cur();
  endtask

  task automatic wipe_pulse();
    @(negedge clk); wipe_n = 1'b0;
    repeat (3) @(negedge clk);
    wipe_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr_strobe = 1'b0; rd_strobe_n = 1'b1; wr_strobe_n = 1'b1;
    wipe_n = 1'b1; bus_in = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    chk("R11 aux", {7'b0, aux_supply_en}, 8'h00);
    chk("R11 xtal", {7'b0, xtal_load_sel}, 8'h00);
    chk("R11 oe", {7'b0, bus_oe}, 8'h00);
    rd(8'h0A); chk("R11 0x0A", rd_v, 8'h00);

    // R5 fixed registers
    for (int a = 0; a < 14; a++) begin
      if (a != 10) begin rd(8'(a)); chk("R5 fixed read", rd_v, 8'hC0 | 8'(a)); end
    end
    wr(8'h03, 8'hFF); rd(8'h03); chk("R5 write ignored", rd_v, 8'hC3);

    // R4 RAM sweep in bank 0
    for (int a = 14; a < 128; a++) wr(8'(a), pat(a, 3));
    for (int a = 14; a < 128; a++) begin rd(8'(a)); chk("R4 ram", rd_v, pat(a, 3)); end

    // R3 output enable
    rd(8'h20); chk("R3 oe during read", {7'b0, oe_v}, 8'h01);
    #1; chk("R3 oe after read", {7'b0, bus_oe}, 8'h00);
    @(negedge clk); addr_strobe = 1'b1; rd_strobe_n = 1'b0; #2;
    chk("R3 oe while addr strobe", {7'b0, bus_oe}, 8'h00);
    @(negedge clk); rd_strobe_n = 1'b1; addr_strobe = 1'b0;

    // R1 address held after latch
    addr_cycle(8'h21);
    bus_in = 8'h55; repeat (2) @(negedge clk);
    rd_cur(); chk("R1 latched addr", rd_v, pat(33, 3));

    // R2 byte present at rising write strobe is stored
    addr_cycle(8'h30);
    bus_in = 8'h11; wr_strobe_n = 1'b0;
    @(negedge clk); bus_in = 8'h99;
    @(negedge clk); wr_strobe_n = 1'b1;
    @(negedge clk);
    rd(8'h30); chk("R2 last byte", rd_v, 8'h99);
    wr(8'h30, pat(48, 3));

    // R6 bank select register
    wr(8'h0A, 8'h10); rd(8'h0A); chk("R6 0x0A readback", rd_v, 8'h10);

    // R7 bank 1 space
    wr(8'h50, 8'h5A);
    for (int a = 64; a < 128; a++) begin
      rd(8'(a)); chk("R7 bank1 idle", rd_v, 8'h00);
    end
    wr(8'h4B, 8'hFF); rd(8'h4B); chk("R7 xctl read", rd_v, 8'h03);
    chk("R7 aux pin", {7'b0, aux_supply_en}, 8'h01);
    chk("R7 xtal pin", {7'b0, xtal_load_sel}, 8'h01);
    wr(8'h4B, 8'h02);
    chk("R7 aux cleared", {7'b0, aux_supply_en}, 8'h00);
    chk("R7 xtal kept", {7'b0, xtal_load_sel}, 8'h01);
    wr(8'h4A, 8'hFF); rd(8'h4A); chk("R7 wipecfg read", rd_v, 8'h01);
    rd(8'h20); chk("R4 low ram in bank1", rd_v, pat(32, 3));
    wr(8'h0A, 8'h00);
    rd(8'h50); chk("R7 bank0 ram untouched", rd_v, pat(80, 3));
    rd(8'h4A); chk("R7 bank0 4A is ram", rd_v, pat(74, 3));

    // R8 unmapped upper half
    for (int a = 128; a < 256; a++) wr(8'(a), 8'hEE);
    for (int a = 128; a < 256; a++) begin rd(8'(a)); chk("R8 unmapped", rd_v, 8'h00); end
    for (int a = 14; a < 128; a++) begin rd(8'(a)); chk("R8 no alias", rd_v, pat(a, 3)); end

    // R9 / R10 enabled wipe
    wipe_pulse();
    wr(8'h0E, 8'h77);
    wr(8'h0A, 8'h20);
    repeat (130) @(negedge clk);
    rd(8'h0A); chk("R10 reg write during wipe", rd_v, 8'h20);
    rd(8'h0E); chk("R10 ram write dropped", rd_v, 8'h00);
    for (int a = 14; a < 128; a++) begin rd(8'(a)); chk("R9 wiped", rd_v, 8'h00); end

    // R9 disabled wipe
    wr(8'h0A, 8'h10); wr(8'h4A, 8'h00); wr(8'h0A, 8'h00);
    for (int a = 14; a < 128; a++) wr(8'(a), pat(a, 9));
    wipe_pulse();
    repeat (130) @(negedge clk);
    for (int a = 14; a < 128; a++) begin rd(8'(a)); chk("R9 gated off", rd_v, pat(a, 9)); end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule